// File: doc/BRIEF.md
# Transport Packet Sync Word Extractor

This block sits behind an inner convolutional decoder. It turns the decoded serial bit stream into aligned transport bytes. It finds byte and packet alignment by hunting for the sync byte that opens every packet, checks that alignment over several packets, and then flags the first byte of each packet while it holds lock.

There are two packet formats. In the main format a packet is 204 bytes long, including 16 parity bytes. Its sync byte is 0x47, and on every eighth packet the sync byte is sent bit-inverted as 0xB8. The block marks that inverted packet as the head of an eight-packet group. In the alternate format a packet is 147 bytes long and always opens with 0x1D.

The hunt can be switched off. With the hunt off, bytes are still assembled every eight valid bits, but the bit phase stays where it was and no lock is declared. This suits streams that carry only convolutional coding.

Top module: `tsync_extract`

## Requirements
- R1: Directly after reset, `byte_vld`, `pkt_start`, `grp_start` and `lock` are all 0.
- R2: While not aligned and `sync_en` is 1, every valid bit closes an 8-bit window of the latest bits, with the first-received bit as the MSB. The first window equal to a sync byte becomes a byte boundary, and that sync byte is output. Sync bytes are 0x47 or 0xB8 when `dss_mode`=0, and 0x1D when `dss_mode`=1.
- R3: Bytes are sent MSB first. Once aligned, `byte_vld` pulses for one cycle, in the cycle after every eighth valid bit, and `byte_out` then holds those eight bits.
- R4: `lock` rises together with the output of the third consecutive sync byte found at packet spacing: 204 bytes when `dss_mode`=0, 147 bytes when `dss_mode`=1.
- R5: Before lock, a missing sync byte at the expected packet position restarts the hunt, and the count of confirmed sync bytes starts again from zero.
- R6: While locked, `lock` falls with the output of the fourth consecutive packet-position byte that is not a sync byte. Any sync byte found at that position clears the miss count.
- R7: `pkt_start` is 1 exactly on the output byte at packet position 0 whose update leaves `lock` at 1.
- R8: `grp_start` is 1 exactly when `pkt_start` is 1, `dss_mode`=0 and the byte is 0xB8. It is never 1 when `dss_mode`=1.
- R9: With `sync_en`=0 no hunt runs, `lock` and `pkt_start` stay 0, and a byte is output every eight valid bits, counted from the bit phase already in place.
- R10: Cycles with `bit_vld`=0 are ignored, and `byte_vld` is 0 in the cycle after each of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dss_mode | input | 1 | 0: 204-byte packets with 0x47/0xB8 sync; 1: 147-byte packets with 0x1D sync |
| sync_en | input | 1 | 1 enables sync hunting and lock; 0 holds the bit phase |
| bit_vld | input | 1 | Qualifies `bit_in` |
| bit_in | input | 1 | Decoded serial bit |
| byte_out | output | 8 | Assembled byte |
| byte_vld | output | 1 | One-cycle strobe for `byte_out` |
| pkt_start | output | 1 | Marks the packet-position-0 byte while locked |
| grp_start | output | 1 | Marks the inverted-sync packet that opens an eight-packet group |
| lock | output | 1 | Packet alignment confirmed |

## Verification
The assertions assume that `dss_mode` changes only while reset is held, and that `bit_in` carries meaning only when `bit_vld` is high. The stimulus sets the mode before it releases reset and never changes it within a run. Before the first sync byte, and in every run that is meant to fall back into hunting, the stimulus sends only zero bytes. No bit window in those stretches can then equal a sync pattern, so the expected alignment is exactly the one the bench built.

// File: rtl/tsync_pkg.sv
// Shared types for the transport sync extractor.
package tsync_pkg;
    // Alignment state: searching, confirming, or holding packet lock.
    typedef enum logic [1:0] {
        ST_HUNT   = 2'd0,
        ST_VERIFY = 2'd1,
        ST_LOCKED = 2'd2
    } lock_state_t;
endpackage

// File: rtl/tsync_bitalign.sv
// Bit-to-byte assembler with sync-window detection.
// Shifts valid bits into an 8-bit window (first bit = MSB). When hunting,
// any window equal to a sync byte forces a byte boundary; otherwise a byte
// closes every eighth valid bit. Assumes dss_mode is static between resets.
module tsync_bitalign #(
    parameter logic [7:0] SYNC_MAIN  = 8'h47,
    parameter logic [7:0] SYNC_ALT   = 8'h1D,
    parameter bit         ACCEPT_INV = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_vld,
    input  logic       bit_in,
    input  logic       dss_mode,
    input  logic       hunt_en,
    output logic       byte_done,
    output logic [7:0] byte_val,
    output logic       realign,
    output logic       sync_hit,
    output logic       inv_hit
);
    logic [6:0] hist;
    logic [2:0] phase;
    logic       hit_main;
    logic       hit_alt;
    logic       hit_inv;

    assign byte_val = {hist, bit_in};
    assign hit_main = (byte_val == SYNC_MAIN);
    assign hit_alt  = (byte_val == SYNC_ALT);

    // Inverted main sync is only recognised when the variant allows it.
    generate
        if (ACCEPT_INV) begin : g_inv
            assign hit_inv = (byte_val == ~SYNC_MAIN);
        end else begin : g_noinv
            assign hit_inv = 1'b0;
        end
    endgenerate

    // Pick the sync set of the active packet format.
    always_comb begin
        sync_hit  = dss_mode ? hit_alt : (hit_main | hit_inv);
        inv_hit   = !dss_mode && hit_inv;
        realign   = bit_vld && hunt_en && sync_hit;
        byte_done = bit_vld && (realign || phase == 3'd7);
    end

    // Shift history and advance the bit phase on each valid bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist  <= '0;
            phase <= '0;
        end else if (bit_vld) begin
            hist  <= byte_val[6:0];
            phase <= byte_done ? 3'd0 : phase + 3'd1;
        end
    end
endmodule

// File: rtl/tsync_pktcount.sv
// Byte position counter within a packet.
// Reports whether the byte now completing sits at packet position 0.
// A realignment forces position 0. Assumes mode is static between resets.
module tsync_pktcount #(
    parameter int PKT_MAIN = 204,
    parameter int PKT_ALT  = 147
) (
    input  logic clk,
    input  logic rst_n,
    input  logic byte_done,
    input  logic realign,
    input  logic dss_mode,
    output logic at_head
);
    localparam int PKT_MAX = (PKT_MAIN > PKT_ALT) ? PKT_MAIN : PKT_ALT;
    localparam int IW      = $clog2(PKT_MAX);

    logic [IW-1:0] idx;
    logic [IW-1:0] cur;
    logic [IW-1:0] last;

    // Position of the completing byte and the last position of the packet.
    always_comb begin
        cur     = realign ? '0 : idx;
        last    = dss_mode ? IW'(PKT_ALT - 1) : IW'(PKT_MAIN - 1);
        at_head = (cur == '0);
    end

    // Step to the next byte position, wrapping at the packet length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (byte_done) begin
            idx <= (cur >= last) ? '0 : cur + 1'b1;
        end
    end

    a_r4_pos_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        idx <= (dss_mode ? IW'(PKT_ALT - 1) : IW'(PKT_MAIN - 1)));
endmodule

// File: rtl/tsync_lockfsm.sv
// Lock state machine: hunt, confirm LOCK_N packet heads, hold lock until
// MISS_N consecutive heads lack a sync byte. Disabling sync forces hunt.
// Assumes LOCK_N >= 2 and MISS_N >= 1.
module tsync_lockfsm
    import tsync_pkg::*;
#(
    parameter int LOCK_N = 3,
    parameter int MISS_N = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_en,
    input  logic byte_done,
    input  logic realign,
    input  logic at_head,
    input  logic sync_hit,
    output logic hunting,
    output logic locked,
    output logic lock_next
);
    localparam int CMAX = (LOCK_N > MISS_N) ? LOCK_N : MISS_N;
    localparam int CW   = $clog2(CMAX + 1);

    lock_state_t   st, st_n;
    logic [CW-1:0] cnt, cnt_n, cnt_inc;

    assign cnt_inc = cnt + 1'b1;

    // Next state: count confirmations before lock, misses after.
    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        if (!sync_en) begin
            st_n  = ST_HUNT;
            cnt_n = '0;
        end else if (byte_done) begin
            case (st)
                ST_HUNT: begin
                    if (realign) begin
                        st_n  = ST_VERIFY;
                        cnt_n = CW'(1);
                    end
                end
                ST_VERIFY: begin
                    if (at_head) begin
                        if (!sync_hit) begin
                            st_n  = ST_HUNT;
                            cnt_n = '0;
                        end else if (cnt_inc >= CW'(LOCK_N)) begin
                            st_n  = ST_LOCKED;
                            cnt_n = '0;
                        end else begin
                            cnt_n = cnt_inc;
                        end
                    end
                end
                ST_LOCKED: begin
                    if (at_head) begin
                        if (sync_hit) begin
                            cnt_n = '0;
                        end else if (cnt_inc >= CW'(MISS_N)) begin
                            st_n  = ST_HUNT;
                            cnt_n = '0;
                        end else begin
                            cnt_n = cnt_inc;
                        end
                    end
                end
                default: begin
                    st_n  = ST_HUNT;
                    cnt_n = '0;
                end
            endcase
        end
    end

    // State and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= ST_HUNT;
            cnt <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
        end
    end

    assign hunting   = (st == ST_HUNT);
    assign locked    = (st == ST_LOCKED);
    assign lock_next = (st_n == ST_LOCKED);

    // R4: lock is only entered from the confirming state.
    a_r4_lock_via_verify: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LOCKED && $past(st) != ST_LOCKED) |-> $past(st) == ST_VERIFY);
    // R6: miss count never reaches the loss threshold while locked.
    a_r6_miss_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LOCKED) |-> (cnt < CW'(MISS_N)));
endmodule

// File: rtl/tsync_extract.sv
// Transport packet sync extractor top level.
// Serial bits in, aligned bytes out with packet-head, group-head and lock
// flags, registered one cycle after the completing bit.
// Assumes dss_mode changes only under reset.
module tsync_extract
    import tsync_pkg::*;
#(
    parameter int         PKT_MAIN  = 204,
    parameter int         PKT_ALT   = 147,
    parameter logic [7:0] SYNC_MAIN = 8'h47,
    parameter logic [7:0] SYNC_ALT  = 8'h1D,
    parameter int         LOCK_N    = 3,
    parameter int         MISS_N    = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dss_mode,
    input  logic       sync_en,
    input  logic       bit_vld,
    input  logic       bit_in,
    output logic [7:0] byte_out,
    output logic       byte_vld,
    output logic       pkt_start,
    output logic       grp_start,
    output logic       lock
);
    logic       byte_done, realign, sync_hit, inv_hit;
    logic [7:0] byte_val;
    logic       at_head, hunting, locked, lock_next;
    logic       hunt_en;

    assign hunt_en = sync_en && hunting;

    tsync_bitalign #(
        .SYNC_MAIN (SYNC_MAIN),
        .SYNC_ALT  (SYNC_ALT),
        .ACCEPT_INV(1'b1)
    ) u_align (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_vld  (bit_vld),
        .bit_in   (bit_in),
        .dss_mode (dss_mode),
        .hunt_en  (hunt_en),
        .byte_done(byte_done),
        .byte_val (byte_val),
        .realign  (realign),
        .sync_hit (sync_hit),
        .inv_hit  (inv_hit)
    );

    tsync_pktcount #(
        .PKT_MAIN(PKT_MAIN),
        .PKT_ALT (PKT_ALT)
    ) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .byte_done(byte_done),
        .realign  (realign),
        .dss_mode (dss_mode),
        .at_head  (at_head)
    );

    tsync_lockfsm #(
        .LOCK_N(LOCK_N),
        .MISS_N(MISS_N)
    ) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_en  (sync_en),
        .byte_done(byte_done),
        .realign  (realign),
        .at_head  (at_head),
        .sync_hit (sync_hit),
        .hunting  (hunting),
        .locked   (locked),
        .lock_next(lock_next)
    );

    assign lock = locked;

    // Register the byte and its flags one cycle after the completing bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_out  <= '0;
            byte_vld  <= 1'b0;
            pkt_start <= 1'b0;
            grp_start <= 1'b0;
        end else begin
            byte_vld  <= byte_done;
            pkt_start <= byte_done && at_head && lock_next;
            grp_start <= byte_done && at_head && lock_next && inv_hit;
            if (byte_done) begin
                byte_out <= byte_val;
            end
        end
    end

    // R3/R10: a byte strobe always follows a valid bit.
    a_r3_vld_after_bit: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |-> $past(bit_vld));
    // R7: packet head is flagged only under lock.
    a_r7_start_locked: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_start |-> lock);
    // R8: group head is an inverted-sync packet head in the main format.
    a_r8_grp_is_inv_head: assert property (@(posedge clk) disable iff (!rst_n)
        grp_start |-> (pkt_start && byte_out == ~SYNC_MAIN && !dss_mode));
    // R9: with sync disabled, lock is low from the next cycle on.
    a_r9_off_no_lock: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_en |=> !lock);
endmodule

// File: tb/tb_tsync_extract.sv
`timescale 1ns/1ps
module tb_tsync_extract;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dss_mode = 1'b0;
    logic       sync_en = 1'b1;
    logic       bit_vld = 1'b0;
    logic       bit_in = 1'b0;
    logic [7:0] byte_out;
    logic       byte_vld, pkt_start, grp_start, lock;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 1'b0;
    int  gap_ctr = 0;

    always #2.5 clk = ~clk;

    tsync_extract dut (
        .clk(clk), .rst_n(rst_n), .dss_mode(dss_mode), .sync_en(sync_en),
        .bit_vld(bit_vld), .bit_in(bit_in), .byte_out(byte_out),
        .byte_vld(byte_vld), .pkt_start(pkt_start), .grp_start(grp_start),
        .lock(lock)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input bit dss, input bit en);
        @(negedge clk);
        rst_n = 1'b0; bit_vld = 1'b0; dss_mode = dss; sync_en = en;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        gap_ctr = 0;
    endtask

    // Drive one valid bit, optionally preceded by an idle cycle (R10).
    task automatic send_bit(input bit b, input int gap_every);
        if (gap_every > 0) begin
            gap_ctr++;
            if (gap_ctr % gap_every == 0) begin
                @(negedge clk);
                bit_vld = 1'b0;
                @(posedge clk); #1;
                chk(byte_vld == 1'b0, "R10 idle strobe", byte_vld, 0);
            end
        end
        @(negedge clk);
        bit_vld = 1'b1; bit_in = b;
        @(posedge clk); #1;
    endtask

    function automatic logic [7:0] gen_byte(input bit dss, input bit zpl,
                                            input int bad, input int p, input int i);
        if (i == 0) begin
            if (bad[p]) return 8'h00;
            if (dss) return 8'h1D;
            return (p % 8 == 0) ? 8'hB8 : 8'h47;
        end
        if (zpl) return 8'h00;
        return 8'((p * 37 + i * 11 + 5) & 255);
    endfunction

    // Full stream: zero prefix, npk packets, arithmetic expectations.
    task automatic run_stream(input bit dss, input int pre, input int npk,
                              input int bad, input int lock_pkt, input int unlock_pkt,
                              input bit zpl, input int gap, input string ltag);
        int plen;
        plen = dss ? 147 : 204;
        do_reset(dss, 1'b1);
        for (int k = 0; k < pre; k++) send_bit(1'b0, gap);
        for (int p = 0; p < npk; p++) begin
            for (int i = 0; i < plen; i++) begin
                logic [7:0] v;
                bit exp_lock, exp_ps, exp_gs;
                v = gen_byte(dss, zpl, bad, p, i);
                exp_lock = (p >= lock_pkt) && (p < unlock_pkt);
                exp_ps   = (i == 0) && exp_lock;
                exp_gs   = exp_ps && !dss && (v == 8'hB8);
                for (int b = 7; b >= 0; b--) begin
                    send_bit(v[b], gap);
                    if (b != 0) begin
                        if (!(p == 0 && i == 0))
                            chk(byte_vld == 1'b0, "R3 strobe spacing", byte_vld, 0);
                    end else begin
                        chk(byte_vld == 1'b1 && byte_out == v,
                            (p == 0 && i == 0) ? "R2 first sync byte" : "R3 byte data",
                            {byte_vld, byte_out}, {1'b1, v});
                        chk(lock == exp_lock, ltag, lock, exp_lock);
                        chk(pkt_start == exp_ps, "R7 packet start", pkt_start, exp_ps);
                        chk(grp_start == exp_gs, "R8 group start", grp_start, exp_gs);
                    end
                end
            end
        end
        @(negedge clk);
        bit_vld = 1'b0;
    endtask

    // Search disabled: bytes every 8 bits from reset phase, never lock (R9).
    task automatic run_nosearch();
        logic [7:0] sh;
        int cnt;
        sh = '0; cnt = 0;
        do_reset(1'b0, 1'b0);
        for (int k = 0; k < 3 + 3 * 204 * 8; k++) begin
            bit b;
            if (k < 3) b = k[0];
            else begin
                logic [7:0] v;
                v = gen_byte(1'b0, 1'b0, 0, (k - 3) / 1632, ((k - 3) / 8) % 204);
                b = v[7 - ((k - 3) % 8)];
            end
            send_bit(b, 0);
            sh = {sh[6:0], b};
            cnt++;
            if (cnt % 8 == 0)
                chk(byte_vld && byte_out == sh, "R9 held phase byte", {byte_vld, byte_out}, {1'b1, sh});
            else
                chk(!byte_vld, "R9 held phase strobe", byte_vld, 0);
            chk(!lock && !pkt_start, "R9 no lock", {lock, pkt_start}, 0);
        end
        @(negedge clk);
        bit_vld = 1'b0;
    endtask

    initial begin
        do_reset(1'b0, 1'b1);
        @(posedge clk); #1;
        chk(byte_vld == 0 && pkt_start == 0 && grp_start == 0 && lock == 0,
            "R1 reset state", {byte_vld, pkt_start, grp_start, lock}, 0);
        // Main format: phase sweep; two long runs reach the group head.
        run_stream(1'b0, 16, 9, 0, 2, 9999, 1'b0, 0, "R4 lock main");
        run_stream(1'b0, 21, 9, 0, 2, 9999, 1'b0, 0, "R4 lock main");
        for (int ph = 17; ph <= 23; ph++)
            if (ph != 21) run_stream(1'b0, ph, 4, 0, 2, 9999, 1'b0, 0, "R4 lock main");
        // Alternate format, with and without idle cycles.
        run_stream(1'b1, 16, 5, 0, 2, 9999, 1'b0, 5, "R4 lock alt");
        run_stream(1'b1, 21, 5, 0, 2, 9999, 1'b0, 0, "R4 lock alt");
        // Miss before lock restarts the count.
        run_stream(1'b0, 16, 6, 32'h4, 5, 9999, 1'b1, 0, "R5 relock");
        // Misses while locked: three, a good one, then four.
        run_stream(1'b0, 19, 11, 32'h7B8, 2, 10, 1'b1, 0, "R6 loss");
        run_nosearch();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 190000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule